// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Resolver

This block closes out an interrupt acknowledge cycle and hands the processor the exception vector number it should use. A one-cycle start strobe opens the cycle and carries the 3-bit level being acknowledged. From then on the block samples the active-low termination inputs on every rising clock edge. These are autovector, data-size acknowledge, bus error and halt. The block settles the cycle by fixed priority.

Four outcomes are possible:
- A normal acknowledge takes the vector from the 8-bit data bus.
- An autovector, raised from outside or by a per-level enable bit, yields the level plus 24.
- A bus error with no responder yields the spurious vector 24.
- Bus error together with halt asks for a retry and restarts the wait.

After a result the block returns to idle and ignores every termination input until the next start strobe.

Top module: `iack_vector_unit`

## Requirements
- R1: After reset, `vecValid` and `retryReq` are low, and they stay low while no acknowledge cycle is open.
- R2: When `dsackN` is low at an edge while waiting, and no other termination applies, `vecOut` equals the `dataBus` value sampled at that edge. It is shown with `vecValid` high in the following cycle.
- R3: When `avecN` is low at an edge while waiting and `pinIsCs` is 0, the vector is level + 24 and `dataBus` is ignored. This also holds when `dsackN` is low at the same edge.
- R4: When `pinIsCs` is 1, a low `avecN` is not recognised. The cycle keeps waiting until another termination arrives.
- R5: Bit n-1 of `autoVecEn` (levels 1 to 7) makes the block produce level + 24 at the first edge after the start, with no termination input.
- R6: When `berrN` is low and `haltN` is high at an edge while waiting, the vector is 24. This takes precedence over autovector and data-size acknowledge.
- R7: When `berrN` and `haltN` are both low at an edge while waiting, `retryReq` pulses for one cycle and no vector is given. The block keeps waiting, and a later termination completes the cycle.
- R8: A level of 0 at the start yields the spurious vector 24 at the first edge after the start, unless a retry applies.
- R9: `vecValid` and `retryReq` are never high together. `vecValid` is high for exactly one cycle per completed acknowledge cycle.
- R10: Termination inputs have no effect outside an open acknowledge cycle. That includes the cycles after a result and before the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ackStart | input | 1 | Opens an acknowledge cycle when idle |
| ackLevel | input | 3 | Interrupt level being acknowledged |
| avecN | input | 1 | External autovector request, active low |
| dsackN | input | 1 | Data-size acknowledge, active low |
| berrN | input | 1 | Bus error, active low |
| haltN | input | 1 | Halt, active low |
| dataBus | input | 8 | Vector supplied by the responding device |
| autoVecEn | input | 7 | Per-level internal autovector enables, bit 0 = level 1 |
| pinIsCs | input | 1 | 1: the shared pin is a chip select and external autovector is disabled |
| vecOut | output | 8 | Resolved vector number, meaningful while vecValid is high |
| vecValid | output | 1 | One-cycle pulse marking a delivered vector |
| retryReq | output | 1 | One-cycle pulse requesting a rerun of the acknowledge cycle |

## Verification
A wrong controller state shows up at the ports one cycle after the edge that should have ended the cycle. Three symptoms are possible: a missing or doubled `vecValid` pulse, a `retryReq` where a vector was due, or a result produced while idle. A wrong captured level, or a wrong choice of vector source, shows up as a bad `vecOut` in that same pulse cycle. The bench sweeps every level against every termination form, including the priority collisions, so each such fault shows within a few cycles of the start strobe.

// File: rtl/iack_pkg.sv
package iack_pkg;

  // Strobes from control to datapath, one per capture action.
  typedef struct packed {
    logic loadLevel;
    logic takeData;
    logic takeAuto;
    logic takeSpur;
  } dpStrobeT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ackStateT;

endpackage

// File: rtl/iack_datapath.sv
module iack_datapath
  import iack_pkg::*;
#(
  parameter int LEVEL_W   = 3,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24,
  parameter int SPUR_VEC  = 24
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobeT                    stb,
  input  logic [LEVEL_W-1:0]          ackLevel,
  input  logic [(2**LEVEL_W)-2:0]     autoVecEn,
  input  logic                        avecN,
  input  logic                        dsackN,
  input  logic                        berrN,
  input  logic                        haltN,
  input  logic                        pinIsCs,
  input  logic [VEC_W-1:0]            dataBus,
  output logic                        levelZero,
  output logic                        autoInt,
  output logic                        avecSeen,
  output logic                        dsackSeen,
  output logic                        berrSeen,
  output logic                        haltSeen,
  output logic [VEC_W-1:0]            vecOut
);

  localparam int NUM_LEVELS = (2**LEVEL_W) - 1;
  localparam logic [VEC_W-1:0] AUTO_BASE_V = VEC_W'(AUTO_BASE);
  localparam logic [VEC_W-1:0] SPUR_VEC_V  = VEC_W'(SPUR_VEC);

  logic [LEVEL_W-1:0] levelQ;
  logic [VEC_W-1:0]   vecQ;
  logic [VEC_W-1:0]   autoVec;
  logic [NUM_LEVELS:0] lvlHit;

  // Level captured at the start strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelQ <= '0;
    else if (stb.loadLevel) levelQ <= ackLevel;
  end

  // Per-level internal autovector decode
  assign lvlHit[0] = 1'b0;
  generate
    for (genvar g = 1; g <= NUM_LEVELS; g++) begin : gLevel
      assign lvlHit[g] = autoVecEn[g-1] && (levelQ == LEVEL_W'(g));
    end
  endgenerate

  assign autoInt   = |lvlHit;
  assign levelZero = (levelQ == '0);
  // The shared pin only counts as autovector when it is not a chip select
  assign avecSeen  = !avecN && !pinIsCs;
  assign dsackSeen = !dsackN;
  assign berrSeen  = !berrN;
  assign haltSeen  = !haltN;

  assign autoVec = AUTO_BASE_V + {{(VEC_W-LEVEL_W){1'b0}}, levelQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vecQ <= '0;
    else if (stb.takeSpur) vecQ <= SPUR_VEC_V;
    else if (stb.takeAuto) vecQ <= autoVec;
    else if (stb.takeData) vecQ <= dataBus;
  end

  assign vecOut = vecQ;

endmodule

// File: rtl/iack_ctrl.sv
module iack_ctrl
  import iack_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ackStart,
  input  logic     levelZero,
  input  logic     autoInt,
  input  logic     avecSeen,
  input  logic     dsackSeen,
  input  logic     berrSeen,
  input  logic     haltSeen,
  output dpStrobeT stb,
  output logic     waiting,
  output logic     vecValid,
  output logic     retryReq
);

  ackStateT stateQ, stateD;
  logic     finish;
  logic     retry;
  logic     validQ;
  logic     retryQ;

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    finish = 1'b0;
    retry  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (ackStart) begin
          stb.loadLevel = 1'b1;
          stateD        = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (berrSeen && haltSeen) begin
          retry = 1'b1;                 // rerun: remain waiting
        end else if (levelZero || berrSeen) begin
          stb.takeSpur = 1'b1;
          finish       = 1'b1;
        end else if (autoInt || avecSeen) begin
          stb.takeAuto = 1'b1;          // data bus discarded
          finish       = 1'b1;
        end else if (dsackSeen) begin
          stb.takeData = 1'b1;
          finish       = 1'b1;
        end
        if (finish) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      validQ <= 1'b0;
      retryQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      validQ <= finish;
      retryQ <= retry;
    end
  end

  assign waiting  = (stateQ == ST_WAIT);
  assign vecValid = validQ;
  assign retryReq = retryQ;

endmodule

// File: rtl/iack_vector_unit.sv
module iack_vector_unit
  import iack_pkg::*;
#(
  parameter int LEVEL_W   = 3,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24,
  parameter int SPUR_VEC  = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ackStart,
  input  logic [LEVEL_W-1:0]      ackLevel,
  input  logic                    avecN,
  input  logic                    dsackN,
  input  logic                    berrN,
  input  logic                    haltN,
  input  logic [VEC_W-1:0]        dataBus,
  input  logic [(2**LEVEL_W)-2:0] autoVecEn,
  input  logic                    pinIsCs,
  output logic [VEC_W-1:0]        vecOut,
  output logic                    vecValid,
  output logic                    retryReq
);

  dpStrobeT stb;
  logic     waiting;
  logic     levelZero, autoInt, avecSeen, dsackSeen, berrSeen, haltSeen;

  iack_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ackStart  (ackStart),
    .levelZero (levelZero),
    .autoInt   (autoInt),
    .avecSeen  (avecSeen),
    .dsackSeen (dsackSeen),
    .berrSeen  (berrSeen),
    .haltSeen  (haltSeen),
    .stb       (stb),
    .waiting   (waiting),
    .vecValid  (vecValid),
    .retryReq  (retryReq)
  );

  iack_datapath #(
    .LEVEL_W   (LEVEL_W),
    .VEC_W     (VEC_W),
    .AUTO_BASE (AUTO_BASE),
    .SPUR_VEC  (SPUR_VEC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .ackLevel  (ackLevel),
    .autoVecEn (autoVecEn),
    .avecN     (avecN),
    .dsackN    (dsackN),
    .berrN     (berrN),
    .haltN     (haltN),
    .pinIsCs   (pinIsCs),
    .dataBus   (dataBus),
    .levelZero (levelZero),
    .autoInt   (autoInt),
    .avecSeen  (avecSeen),
    .dsackSeen (dsackSeen),
    .berrSeen  (berrSeen),
    .haltSeen  (haltSeen),
    .vecOut    (vecOut)
  );

endmodule

// File: rtl/iack_checker.sv
module iack_checker #(
  parameter int VEC_W    = 8,
  parameter int SPUR_VEC = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             waiting,
  input logic             berrN,
  input logic             haltN,
  input logic             vecValid,
  input logic             retryReq,
  input logic [VEC_W-1:0] vecOut
);

  // R9
  valid_retry_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(vecValid && retryReq));

  // R9
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

  // R6
  spurious_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && !berrN && haltN) |=> (vecValid && vecOut == VEC_W'(SPUR_VEC)));

  // R7
  retry_no_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && !berrN && !haltN) |=> (retryReq && !vecValid));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !waiting |=> (!vecValid && !retryReq));

endmodule

bind iack_vector_unit iack_checker #(
  .VEC_W    (VEC_W),
  .SPUR_VEC (SPUR_VEC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .waiting  (waiting),
  .berrN    (berrN),
  .haltN    (haltN),
  .vecValid (vecValid),
  .retryReq (retryReq),
  .vecOut   (vecOut)
);

// File: tb/sim_iack_vector_unit.sv
module sim_iack_vector_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ackStart = 1'b0;
  logic [2:0] ackLevel = '0;
  logic       avecN = 1'b1, dsackN = 1'b1, berrN = 1'b1, haltN = 1'b1;
  logic [7:0] dataBus = '0;
  logic [6:0] autoVecEn = '0;
  logic       pinIsCs = 1'b0;
  logic [7:0] vecOut;
  logic       vecValid, retryReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  iack_vector_unit u0 (
    .clk(clk), .rstN(rstN), .ackStart(ackStart), .ackLevel(ackLevel),
    .avecN(avecN), .dsackN(dsackN), .berrN(berrN), .haltN(haltN),
    .dataBus(dataBus), .autoVecEn(autoVecEn), .pinIsCs(pinIsCs),
    .vecOut(vecOut), .vecValid(vecValid), .retryReq(retryReq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_);
    checks++;
    if (act !== exp_) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_);
    end
  endtask

  task automatic release_all();
    avecN = 1'b1; dsackN = 1'b1; berrN = 1'b1; haltN = 1'b1;
  endtask

  // Open a cycle; returns at the negedge where terminations are driven.
  task automatic open_cycle(input logic [2:0] lvl);
    @(negedge clk);
    ackStart = 1'b1; ackLevel = lvl;
    @(negedge clk);
    ackStart = 1'b0; ackLevel = 3'd0;
  endtask

  task automatic expect_result(input string tag, input logic [7:0] v);
    @(negedge clk);
    chk({tag, " valid"}, {7'd0, vecValid}, 8'd1);
    chk({tag, " retry"}, {7'd0, retryReq}, 8'd0);
    chk({tag, " vector"}, vecOut, v);
    release_all();
    @(negedge clk);
    chk("R9 pulse ends", {7'd0, vecValid}, 8'd0);
  endtask

  // mode 0 dsack, 1 ext avec, 2 avec+dsack, 3 internal, 4 berr (with avec+dsack),
  // 5 berr+halt then dsack, 6 avec while pin is chip select then dsack
  task automatic run(input int mode, input logic [2:0] lvl);
    logic [7:0] d;
    logic [7:0] av;
    d  = 8'(8'h40 + 16 * lvl + mode);
    av = 8'(24 + lvl);
    pinIsCs   = (mode == 6);
    autoVecEn = (mode == 3 && lvl != 0) ? 7'(1 << (lvl - 1)) : 7'd0;
    open_cycle(lvl);
    dataBus = d;
    case (mode)
      0: begin dsackN = 1'b0; expect_result("R2 dsack", (lvl == 0) ? 8'd24 : d); end
      1: begin avecN = 1'b0; expect_result("R3 avec", (lvl == 0) ? 8'd24 : av); end
      2: begin avecN = 1'b0; dsackN = 1'b0; expect_result("R3 avec+dsack", (lvl == 0) ? 8'd24 : av); end
      3: expect_result((lvl == 0) ? "R8 level0" : "R5 internal", (lvl == 0) ? 8'd24 : av);
      4: begin berrN = 1'b0; avecN = 1'b0; dsackN = 1'b0; expect_result("R6 berr", 8'd24); end
      5: begin
        berrN = 1'b0; haltN = 1'b0;
        @(negedge clk);
        chk("R7 retry", {7'd0, retryReq}, 8'd1);
        chk("R7 no valid", {7'd0, vecValid}, 8'd0);
        release_all();
        dsackN = 1'b0;
        expect_result("R7 after retry", (lvl == 0) ? 8'd24 : d);
      end
      default: begin
        avecN = 1'b0;
        if (lvl == 0) expect_result("R8 level0", 8'd24);
        else begin
          @(negedge clk);
          chk("R4 cs ignores avec", {7'd0, vecValid}, 8'd0);
          dsackN = 1'b0;
          expect_result("R4 then dsack", d);
        end
      end
    endcase
    pinIsCs = 1'b0; autoVecEn = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {7'd0, vecValid}, 8'd0);
    chk("R1 reset retry", {7'd0, retryReq}, 8'd0);
    rstN = 1'b1;
    // R10: terminations while idle
    @(negedge clk);
    avecN = 1'b0; dsackN = 1'b0; berrN = 1'b0; dataBus = 8'h77;
    repeat (3) begin
      @(negedge clk);
      chk("R10 idle valid", {7'd0, vecValid}, 8'd0);
      chk("R10 idle retry", {7'd0, retryReq}, 8'd0);
    end
    haltN = 1'b0;
    @(negedge clk);
    chk("R10 idle retry halt", {7'd0, retryReq}, 8'd0);
    release_all();
    for (int m = 0; m < 7; m++)
      for (int l = 0; l < 8; l++) begin
        run(m, 3'(l));
        // R10: after the result, held terminations do nothing
        dsackN = 1'b0; avecN = 1'b0;
        @(negedge clk);
        chk("R10 post result", {7'd0, vecValid}, 8'd0);
        release_all();
      end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule